// File: doc/BRIEF.md
# 64-bit Interval Timer

A memory-mapped up-counter that is twice as wide as the register word. It counts one step per clock while running. When it reaches a programmable rollover value it wraps back to zero. In periodic mode it keeps counting and wrapping until software stops it. In single-shot mode it wraps once, then stops and flags completion. Each wrap can raise a level-sensitive interrupt, which stays high until software clears it by writing one to its status bit.

Software reaches the block through a plain synchronous slave port with a byte address, read and write strobes, write data and registered read data. The port has no valid/ready pair and never applies back-pressure. Every strobe is taken in the cycle it is presented. Read data appears exactly one cycle after the read strobe, and the port holds zero on cycles that follow no read.

Software reads the counter as two words. Reading the low word also captures the live upper word into a holding register, and later reads of the upper offset return that captured value. This gives a consistent 2-word sample. Byte offsets, as 5-bit addresses:

| Offset | Name | Access |
|---|---|---|
| 0x00 | frequency | read-only |
| 0x04 | control | read/write |
| 0x08 | status | write 1 to clear |
| 0x0C | reserved | reads as 0 |
| 0x10 | counter low | read-only |
| 0x14 | counter high | read-only |
| 0x18 | rollover low | read/write |
| 0x1C | rollover high | read/write |

Top module: `ivt_timer`

## Requirements
- R1: After reset, the following are all zero: the control bits, the status bits, the counter, the holding register, both rollover words, `irq` and `bus_rdata`.
- R2: Read data is registered. It is valid in the cycle after the read strobe and is zero in any cycle that follows no read. Offset 0x00 returns the parameter `FREQ_HZ`. If the parameter `FREQ_KNOWN` is 0, it returns all ones instead.
- R3: The control word at 0x04 has these fields:
  - bit 0, run: enables counting.
  - bit 1, interrupt enable.
  - bit 2, single-shot.
  - bit 3, counter clear: self-clearing and always reads 0.

  Higher bits read 0. A control write with bit 0 at 0 also forces the interrupt enable to 0.
- R4: With rollover value R, the counter steps 0, 1, … R, R+1 and then returns to 0, which gives a period of R+2 cycles. In periodic mode this repeats while bit 0 stays set.
- R5: Status bit 0 at 0x08 is set in the cycle after the counter equals R, but only when both the run and interrupt-enable bits are set. `irq` equals status bit 0 and stays high until software writes 1 to that bit.
- R6: A control write that clears bit 0 in the same cycle as a wrap event suppresses that event's interrupt.
- R7: If a write of 1 to status bit 0 falls in the same cycle as a new interrupt event, the bit stays set.
- R8: In single-shot mode a wrap does three things: it clears the run bit, it sets status bit 1 (complete), and it lets the counter settle at 0 and hold there.
- R9: Writing 1 to status bit 1 while it is set and single-shot is still selected clears the bit. It also restarts counting from 0 with the run bit set again.
- R10: A read of 0x10 returns the live low word and captures the live high word. Reads of 0x14 return the captured word until the next read of 0x10.
- R11: Writes to 0x00, 0x0C, 0x10, 0x14 and to non-word-aligned addresses change nothing. Writing 1 to control bit 3 zeroes the counter.
- R12: The two rollover words at 0x18 (low) and 0x1C (high) can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the main instance with `DATA_W` = 8, which makes the counter 16 bits wide. In a run of a few hundred cycles the counter then carries into its upper word, so the captured upper word can be seen to differ from the live value. The bench also builds a second instance with `FREQ_KNOWN` = 0 to reach the all-ones frequency response. Small rollover values keep the wrap-edge collisions with bus writes a few cycles apart, so each collision can be placed on an exact clock edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_FREQ    = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_ROLL_LO = 5'h18;
  localparam int                WORD_BYTES  = 4;

  // control field positions
  localparam int CB_RUN   = 0;
  localparam int CB_IRQEN = 1;
  localparam int CB_SHOT  = 2;
  localparam int CB_ZERO  = 3;
  // status field positions
  localparam int SB_IRQ   = 0;
  localparam int SB_DONE  = 1;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             zero,
  input  logic [CNT_W-1:0] roll,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  // wrap is pipelined: the match is registered, the reset to zero lands a cycle later
  logic pend;

  assign hit = run && !pend && (cnt == roll);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (zero) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (pend) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (run) begin
      cnt  <= cnt + CNT_W'(1);
      pend <= hit;
    end
  end

  // R4: two cycles after a match the counter is back at zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !zero) |=> ##1 (cnt == '0));

  // R4: an ordinary running cycle advances by one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pend && !hit && !zero) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  output logic              run,
  output logic              irq_en,
  output logic              one_shot,
  output logic              zero_cnt,
  output logic [CNT_W-1:0]  roll,
  output logic              irq_flag,
  output logic              done_flag
);
  localparam int NW = CNT_W / DATA_W;

  logic ctrl_wr, stat_wr, sw_stop, irq_evt, done_evt, irq_clr, done_clr, rearm;
  logic [DATA_W-1:0] roll_q [NW];

  assign ctrl_wr  = wr_en && (addr == OFF_CTRL);
  assign stat_wr  = wr_en && (addr == OFF_STAT);
  assign sw_stop  = ctrl_wr && !wdata[CB_RUN];
  assign irq_evt  = hit && irq_en && !sw_stop;
  assign done_evt = hit && one_shot;
  assign irq_clr  = stat_wr && wdata[SB_IRQ];
  assign done_clr = stat_wr && wdata[SB_DONE];
  assign rearm    = done_clr && done_flag && one_shot && !done_evt;
  assign zero_cnt = (ctrl_wr && wdata[CB_ZERO]) || rearm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      irq_en   <= 1'b0;
      one_shot <= 1'b0;
    end else if (ctrl_wr) begin
      run      <= wdata[CB_RUN];
      irq_en   <= wdata[CB_IRQEN] && wdata[CB_RUN];
      one_shot <= wdata[CB_SHOT];
    end else if (rearm) begin
      run      <= 1'b1;
    end else if (done_evt) begin
      run      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (irq_evt)       irq_flag  <= 1'b1;
      else if (irq_clr)  irq_flag  <= 1'b0;
      if (done_evt)      done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_roll
    localparam logic [ADDR_W-1:0] WOFF = OFF_ROLL_LO + ADDR_W'(WORD_BYTES * w);
    always_ff @(posedge clk) begin
      if (!rst_n)                      roll_q[w] <= '0;
      else if (wr_en && addr == WOFF)  roll_q[w] <= wdata;
    end
    assign roll[w*DATA_W +: DATA_W] = roll_q[w];
  end

  // R5: the interrupt rises only out of a cycle with both run and enable set
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(run) && $past(irq_en)));

  // R6: a disabling control write masks a coincident event
  assert_stop_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl_wr && !wdata[CB_RUN] && !irq_flag) |=> !irq_flag);

  // R7: a coincident event beats the clear
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && irq_en && irq_clr && !ctrl_wr) |=> irq_flag);

  // R8: a single-shot wrap stops the counter and flags completion
  assert_shot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && one_shot && !ctrl_wr) |=> (!run && done_flag));

  // R9: clearing completion under single-shot starts the counter again
  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && done_flag && one_shot && !hit && !ctrl_wr) |=> (run && !done_flag));
endmodule

// File: rtl/ivt_rdata.sv
module ivt_rdata
  import ivt_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 64,
  parameter logic [31:0] FREQ_HZ    = 32'd250_000_000,
  parameter bit          FREQ_KNOWN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  roll,
  input  logic              run,
  input  logic              irq_en,
  input  logic              one_shot,
  input  logic              irq_flag,
  input  logic              done_flag,
  output logic [DATA_W-1:0] rdata
);
  localparam int NW = CNT_W / DATA_W;

  logic [DATA_W-1:0] freq_word, hold, nxt;

  if (FREQ_KNOWN) begin : g_freq_known
    assign freq_word = FREQ_HZ[DATA_W-1:0];
  end else begin : g_freq_unknown
    assign freq_word = '1;
  end

  always_comb begin
    nxt = '0;
    if (rd_en) begin
      case (addr)
        OFF_FREQ:   nxt = freq_word;
        OFF_CTRL: begin
          nxt[CB_RUN]   = run;
          nxt[CB_IRQEN] = irq_en;
          nxt[CB_SHOT]  = one_shot;
        end
        OFF_STAT: begin
          nxt[SB_IRQ]  = irq_flag;
          nxt[SB_DONE] = done_flag;
        end
        OFF_CNT_LO: nxt = cnt[DATA_W-1:0];
        OFF_CNT_HI: nxt = hold;
        default:    nxt = '0;
      endcase
      for (int w = 0; w < NW; w++) begin
        if (addr == OFF_ROLL_LO + ADDR_W'(WORD_BYTES * w)) nxt = roll[w*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      hold  <= '0;
    end else begin
      rdata <= nxt;
      if (rd_en && addr == OFF_CNT_LO) hold <= cnt[CNT_W-1:DATA_W];
    end
  end

  // R2: no strobe, no data
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

  // R3: clear bit and unused control bits always read zero
  assert_ctrl_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_CTRL) |=> (rdata[DATA_W-1:CB_ZERO] == '0));

  // R10: the upper-word read returns what the last low-word read captured
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == OFF_CNT_LO) |=> $stable(hold));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] FREQ_HZ    = 32'd250_000_000,
  parameter bit          FREQ_KNOWN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic             run, irq_en, one_shot, zero_cnt, irq_flag, done_flag, hit;
  logic [CNT_W-1:0] roll, cnt;

  ivt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .hit       (hit),
    .run       (run),
    .irq_en    (irq_en),
    .one_shot  (one_shot),
    .zero_cnt  (zero_cnt),
    .roll      (roll),
    .irq_flag  (irq_flag),
    .done_flag (done_flag)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .zero  (zero_cnt),
    .roll  (roll),
    .cnt   (cnt),
    .hit   (hit)
  );

  ivt_rdata #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .FREQ_HZ    (FREQ_HZ),
    .FREQ_KNOWN (FREQ_KNOWN)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .cnt       (cnt),
    .roll      (roll),
    .run       (run),
    .irq_en    (irq_en),
    .one_shot  (one_shot),
    .irq_flag  (irq_flag),
    .done_flag (done_flag),
    .rdata     (bus_rdata)
  );

  assign irq = irq_flag;

  // R1: interrupt is low on the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/ivt_timer_test.sv
`timescale 1ns/1ps
module ivt_timer_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, nf_rdata;
  logic          irq, nf_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] got, got_nf;

  always #2 clk = ~clk;

  ivt_timer #(.DATA_W(DW), .FREQ_HZ(32'h0000_00A5), .FREQ_KNOWN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  ivt_timer #(.DATA_W(DW), .FREQ_HZ(32'h0000_00A5), .FREQ_KNOWN(1'b0)) uut_nofreq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(nf_rdata), .irq(nf_irq));

  typedef struct packed {
    logic       w;
    logic [4:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{1'b0, 5'h00, 8'h00, 8'hA5, 8'd2},   // R2 frequency
    '{1'b1, 5'h00, 8'h3C, 8'h00, 8'd11},
    '{1'b0, 5'h00, 8'h00, 8'hA5, 8'd11},  // R11 read-only untouched
    '{1'b1, 5'h0C, 8'hFF, 8'h00, 8'd11},
    '{1'b0, 5'h0C, 8'h00, 8'h00, 8'd11},  // R11 reserved reads 0
    '{1'b1, 5'h18, 8'h5A, 8'h00, 8'd12},
    '{1'b1, 5'h1C, 8'hC3, 8'h00, 8'd12},
    '{1'b0, 5'h18, 8'h00, 8'h5A, 8'd12},  // R12
    '{1'b0, 5'h1C, 8'h00, 8'hC3, 8'd12},  // R12
    '{1'b1, 5'h04, 8'hFE, 8'h00, 8'd3},
    '{1'b0, 5'h04, 8'h00, 8'h04, 8'd3},   // R3 run=0 forces irq enable off
    '{1'b1, 5'h04, 8'h03, 8'h00, 8'd3},
    '{1'b0, 5'h04, 8'h00, 8'h03, 8'd3},   // R3
    '{1'b1, 5'h04, 8'h08, 8'h00, 8'd11},
    '{1'b0, 5'h10, 8'h00, 8'h00, 8'd11},  // R11 clear bit zeroes counter
    '{1'b1, 5'h10, 8'h77, 8'h00, 8'd11},
    '{1'b0, 5'h10, 8'h00, 8'h00, 8'd11},  // R11 counter not writable
    '{1'b0, 5'h08, 8'h00, 8'h00, 8'd5}    // R5 no interrupt was raised
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    got = bus_rdata; got_nf = nf_rdata;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(1, irq, 0, "irq in reset");            // R1
    chk(1, bus_rdata, 0, "rdata in reset");    // R1
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h04); chk(1, got, 0, "control after reset");
    rd(5'h08); chk(1, got, 0, "status after reset");
    rd(5'h10); chk(1, got, 0, "counter low after reset");
    rd(5'h14); chk(1, got, 0, "holding word after reset");
    rd(5'h18); chk(1, got, 0, "rollover after reset");
    rd(5'h00); chk(2, got_nf, 8'hFF, "unknown frequency");   // R2
    @(negedge clk); chk(2, bus_rdata, 0, "idle read data");  // R2

    for (int i = 0; i < 18; i++) begin
      if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a);
        chk(int'(VEC[i].req), got, VEC[i].e, "table vector");
      end
    end

    // R4 / R5: rollover 5, period 7, irq a cycle after match
    wr(5'h1C, 8'h00); wr(5'h18, 8'h05); wr(5'h04, 8'h08);
    wr(5'h04, 8'h03);
    k = 0;
    while (!irq && k < 50) begin @(negedge clk); k++; end
    chk(5, k, 6, "cycles to first interrupt");
    wr(5'h08, 8'h01);
    chk(5, irq, 0, "interrupt cleared by W1C");
    k = 1;
    while (!irq && k < 50) begin @(negedge clk); k++; end
    chk(4, k, 7, "periodic wrap interval");

    // R7: clear lands on the next event edge
    repeat (6) @(negedge clk);
    wr(5'h08, 8'h01);
    chk(7, irq, 1, "event beats clear");
    rd(5'h08); chk(7, got, 8'h01, "status after collision");
    wr(5'h08, 8'h01);
    chk(5, irq, 0, "plain clear");

    // R6: disabling write on the event edge
    wr(5'h04, 8'h08);
    wr(5'h04, 8'h03);
    repeat (5) @(negedge clk);
    wr(5'h04, 8'h00);
    chk(6, irq, 0, "masked by disable");
    rd(5'h04); chk(6, got, 0, "control after disable");
    repeat (20) @(negedge clk);
    rd(5'h08); chk(6, got, 0, "no status after disable");

    // R8: single shot with rollover 3
    wr(5'h18, 8'h03); wr(5'h04, 8'h08); wr(5'h04, 8'h07);
    repeat (20) @(negedge clk);
    chk(8, irq, 1, "single-shot interrupt");
    rd(5'h04); chk(8, got, 8'h06, "run bit self-cleared");
    rd(5'h08); chk(8, got, 8'h03, "complete flag");
    rd(5'h10); chk(8, got, 0, "counter settled at 0");
    repeat (10) @(negedge clk);
    rd(5'h10); chk(8, got, 0, "counter holds 0");

    // R9: clearing completion restarts
    wr(5'h08, 8'h02);
    rd(5'h04); chk(9, got, 8'h07, "run bit rearmed");
    rd(5'h10); chk(9, got, 8'h01, "counting from 0");
    chk(9, irq, 1, "interrupt untouched by done clear");
    repeat (20) @(negedge clk);
    rd(5'h08); chk(9, got, 8'h03, "completes again");
    rd(5'h04); chk(9, got, 8'h06, "stopped again");
    wr(5'h08, 8'h03); wr(5'h04, 8'h08);

    // R10: atomic two-word read on a 16-bit counter
    wr(5'h18, 8'hFF); wr(5'h1C, 8'hFF); wr(5'h04, 8'h08);
    wr(5'h04, 8'h01);
    repeat (300) @(negedge clk);
    rd(5'h10); chk(10, got, 8'h2C, "live low word");
    repeat (300) @(negedge clk);
    rd(5'h14); chk(10, got, 8'h01, "captured high word");
    rd(5'h10); chk(10, got, 8'h5A, "second low word");
    rd(5'h14); chk(10, got, 8'h02, "recaptured high word");

    // R11: misaligned write ignored, clear zeroes counter
    wr(5'h19, 8'h11);
    rd(5'h18); chk(11, got, 8'hFF, "misaligned write ignored");
    wr(5'h04, 8'h08);
    rd(5'h10); chk(11, got, 0, "counter cleared");
    rd(5'h14); chk(11, got, 0, "high word after clear");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule